// File: doc/BRIEF.md
# Reference Frequency Divider Chain

This block takes a crystal reference clock of 12.8 MHz or 14.4 MHz and divides it through five cascaded counter stages. The result is a comparison-frequency strobe for a channel-select phase detector. A tap between the second and third stages gives a 200 kHz strobe for either crystal, and this strobe times a 4-level FSK demodulator. The chain must therefore keep running whenever the demodulator or the synthesiser is enabled.

All five stages run on the one reference clock. Each stage passes a single-cycle enable strobe to the next, so no derived clocks exist. The first stage always divides by 8. The next three stages each take their ratio from one select bit, which gives eight totals: 10, 12.5, 20 and 25 kHz spacings from either crystal. A fifth stage divides by 1 to 4 and serves an off-chip frequency multiplier. A five-bit selection is captured only on a load strobe. The load strobe also clears every stage counter, so a new ratio always starts from a known phase.

A small controller has three states. It moves between them on these transitions:
- Any state goes to ST_CLEAR when `cfg_load` is high.
- ST_CLEAR goes to ST_RUN when `run_en` is high, and to ST_HALT when it is low.
- ST_HALT goes to ST_RUN when `run_en` rises.
- ST_RUN goes to ST_HALT when `run_en` drops.

Top module: `refdiv_chain`

## Requirements
- R1: While `rst_n` is low, both strobes are low. After reset the held selection is 0. If `run_en` is high when reset is released, the first `cmp_pulse` appears 512 clock cycles after the first rising edge with reset inactive.
- R2: `cfg_sel[0]` sets the second stage. 0 selects ÷8 and 1 selects ÷9. `tap_pulse` therefore repeats every 64 or 72 clock cycles.
- R3: The four main stages multiply to 8 × (8 + `cfg_sel[0]`) × (4 + `cfg_sel[1]`) × (`cfg_sel[2]` ? 4 : 2). For selections 0 to 7 of `cfg_sel[2:0]` this gives 512, 576, 640, 720, 1024, 1152, 1280 and 1440.
- R4: `cfg_sel[4:3]` sets the last stage, and its divisor is the code value plus one. Code 0 bypasses the stage. `cmp_pulse` repeats every R3 product × (`cfg_sel[4:3]` + 1) cycles.
- R5: A cycle with `cfg_load` high captures `cfg_sel`. In the next cycle all counters are cleared and no strobe appears. With `run_en` high, the first `cmp_pulse` then arrives exactly the total ratio in cycles after the capturing edge.
- R6: Changes on `cfg_sel` without `cfg_load` have no effect on either strobe period.
- R7: Each clock edge that samples `run_en` low adds one cycle in which no strobe appears and the counters hold. Counting resumes from the held values.
- R8: Each strobe is one cycle wide. `cmp_pulse` is only ever high together with `tap_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Crystal reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Chain enable (demodulator or synthesiser active) |
| cfg_load | input | 1 | Captures `cfg_sel` and clears all stage counters |
| cfg_sel | input | 5 | [0] stage-2 ratio, [1] stage-3 ratio, [2] stage-4 ratio, [4:3] last-stage code |
| tap_pulse | output | 1 | 200 kHz enable strobe after stage 2 |
| cmp_pulse | output | 1 | Comparison-frequency enable strobe |

## Verification
A counter holding a wrong value, or one that wraps at the wrong ratio, shows up as a wrong distance between strobes. The first `tap_pulse` after a load moves within 72 cycles. The first `cmp_pulse` moves within one full comparison period, which is at most 5760 cycles. A bad controller state shows up differently. A lost clear, a missed pause or a missed capture moves the first strobe after the load or pause. A strobe during ST_CLEAR or ST_HALT appears in the very next cycle.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
    typedef enum logic [1:0] {
        ST_HALT  = 2'd0,
        ST_CLEAR = 2'd1,
        ST_RUN   = 2'd2
    } run_state_t;

    localparam int SEL_W = 5;
endpackage

// File: rtl/refdiv_stage.sv
module refdiv_stage #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick_in,
    input  logic [CNT_W-1:0] ratio,
    output logic             tick_out
);
    logic [CNT_W-1:0] cnt_q;
    logic             at_last;

    // A ratio of 1 keeps the count at zero, so every input tick passes through.
    assign at_last  = (cnt_q == ratio - CNT_W'(1));
    assign tick_out = tick_in & at_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (tick_in) begin
            cnt_q <= at_last ? '0 : cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/refdiv_chain.sv
module refdiv_chain
    import refdiv_pkg::*;
#(
    parameter int FIX_DIV   = 8,
    parameter int FINE_BASE = 8,
    parameter int MID_BASE  = 4,
    parameter int CRS_LO    = 2,
    parameter int CRS_HI    = 4,
    parameter int CNT_W     = 4
) (
    input  logic             clk_ref,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             cfg_load,
    input  logic [SEL_W-1:0] cfg_sel,
    output logic             tap_pulse,
    output logic             cmp_pulse
);
    localparam int NSTG    = 5;
    localparam int TAP_IDX = 2;

    run_state_t       state_q, state_d;
    logic [SEL_W-1:0] sel_q;
    logic             run_tick;
    logic             clr_all;
    logic [CNT_W-1:0] ratio [NSTG];
    logic [NSTG:0]    tick;

    // State register
    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic; a load strobe wins in every state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: begin
                if (cfg_load)    state_d = ST_CLEAR;
                else if (run_en) state_d = ST_RUN;
            end
            ST_CLEAR: begin
                if (cfg_load)    state_d = ST_CLEAR;
                else if (run_en) state_d = ST_RUN;
                else             state_d = ST_HALT;
            end
            ST_RUN: begin
                if (cfg_load)     state_d = ST_CLEAR;
                else if (!run_en) state_d = ST_HALT;
            end
            default: state_d = ST_HALT;
        endcase
    end

    // State outputs
    always_comb begin
        run_tick = 1'b0;
        clr_all  = 1'b0;
        unique case (state_q)
            ST_HALT:  ;
            ST_CLEAR: clr_all  = 1'b1;
            ST_RUN:   run_tick = 1'b1;
            default:  ;
        endcase
    end

    // Selection holding register
    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (cfg_load) begin
            sel_q <= cfg_sel;
        end
    end

    // Per-stage ratios
    always_comb begin
        ratio[0] = CNT_W'(FIX_DIV);
        ratio[1] = CNT_W'(FINE_BASE) + CNT_W'(sel_q[0]);
        ratio[2] = CNT_W'(MID_BASE) + CNT_W'(sel_q[1]);
        ratio[3] = sel_q[2] ? CNT_W'(CRS_HI) : CNT_W'(CRS_LO);
        ratio[4] = CNT_W'(sel_q[4:3]) + CNT_W'(1);
    end

    assign tick[0] = run_tick;

    for (genvar g = 0; g < NSTG; g++) begin : g_stage
        refdiv_stage #(.CNT_W(CNT_W)) u_stage (
            .clk      (clk_ref),
            .rst_n    (rst_n),
            .clr      (clr_all),
            .tick_in  (tick[g]),
            .ratio    (ratio[g]),
            .tick_out (tick[g+1])
        );
    end

    assign tap_pulse = tick[TAP_IDX];
    assign cmp_pulse = tick[NSTG];
endmodule

// File: rtl/refdiv_chain_chk.sv
module refdiv_chain_chk (
    input logic clk_ref,
    input logic rst_n,
    input logic run_en,
    input logic cfg_load,
    input logic tap_pulse,
    input logic cmp_pulse
);
    // R1: strobes stay low while reset is asserted
    always_comb begin
        if (!rst_n) begin
            a_r1_idle_in_reset: assert (!tap_pulse && !cmp_pulse);
        end
    end

    a_r8_cmp_on_tap: assert property (@(posedge clk_ref) disable iff (!rst_n)
        cmp_pulse |-> tap_pulse);

    a_r8_tap_single: assert property (@(posedge clk_ref) disable iff (!rst_n)
        tap_pulse |=> !tap_pulse);

    a_r5_quiet_after_load: assert property (@(posedge clk_ref) disable iff (!rst_n)
        cfg_load |=> (!tap_pulse && !cmp_pulse));

    a_r7_halt_quiet: assert property (@(posedge clk_ref) disable iff (!rst_n)
        !run_en |=> !tap_pulse);
endmodule

bind refdiv_chain refdiv_chain_chk u_chk (
    .clk_ref   (clk_ref),
    .rst_n     (rst_n),
    .run_en    (run_en),
    .cfg_load  (cfg_load),
    .tap_pulse (tap_pulse),
    .cmp_pulse (cmp_pulse)
);

// File: tb/sim_refdiv_chain.sv
module sim_refdiv_chain;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WD_CYCLES  = 190000;
    localparam int unsigned BASE_TOT [8] = '{512, 576, 640, 720, 1024, 1152, 1280, 1440};

    logic       clk_ref = 1'b0;
    logic       rst_n   = 1'b0;
    logic       run_en  = 1'b0;
    logic       cfg_load = 1'b0;
    logic [4:0] cfg_sel = '0;
    logic       tap_pulse, cmp_pulse;

    int n_checks = 0;
    int n_errs   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk_ref = ~clk_ref;

    refdiv_chain u0 (
        .clk_ref   (clk_ref),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .cfg_load  (cfg_load),
        .cfg_sel   (cfg_sel),
        .tap_pulse (tap_pulse),
        .cmp_pulse (cmp_pulse)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Capture a selection; returns at the negedge after the capturing edge
    task automatic do_load(input logic [4:0] sel);
        @(negedge clk_ref);
        cfg_sel  = sel;
        cfg_load = 1'b1;
        run_en   = 1'b1;
        @(negedge clk_ref);
        cfg_load = 1'b0;
    endtask

    // Count negedges until the chosen strobe is seen
    task automatic wait_strobe(input bit use_cmp, input int limit, output int n);
        n = 0;
        forever begin
            @(negedge clk_ref);
            n++;
            if (use_cmp ? cmp_pulse : tap_pulse) begin
                if (use_cmp) chk(tap_pulse === 1'b1, "R8 cmp with tap", int'(tap_pulse), 1);
                break;
            end
            if (n >= limit) break;
        end
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk_ref);
        if (!done) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog: actual %0d expected 0", WD_CYCLES);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
            $finish;
        end
    end

    initial begin
        int n;
        int exp;

        // R1: reset state, then default ratio
        repeat (3) @(negedge clk_ref);
        chk(!tap_pulse && !cmp_pulse, "R1 reset quiet", int'({tap_pulse, cmp_pulse}), 0);
        rst_n  = 1'b1;
        run_en = 1'b1;
        wait_strobe(1'b1, 7000, n);
        chk(n == 512, "R1 default ratio", n, 512);

        // R3/R4/R5: all 32 selections, latency after load equals total ratio
        for (int s = 0; s < 32; s++) begin
            exp = int'(BASE_TOT[s & 7]) * ((s >> 3) + 1);
            do_load(5'(s));
            wait_strobe(1'b1, 7000, n);
            chk(n == exp, (s >= 8) ? "R4 last stage ratio" : "R3 main ratio", n, exp);
        end

        // R3: steady-state interval for the largest ratio
        wait_strobe(1'b1, 7000, n);
        chk(n == 5760, "R3 repeat interval", n, 5760);

        // R2 and R8: tap intervals and width
        for (int b = 0; b < 2; b++) begin
            do_load(5'(b));
            wait_strobe(1'b0, 200, n);
            chk(n == 64 + 8 * b, "R2 first tap", n, 64 + 8 * b);
            @(negedge clk_ref);
            chk(tap_pulse == 1'b0, "R8 tap one cycle", int'(tap_pulse), 0);
            wait_strobe(1'b0, 200, n);
            chk(n == 63 + 8 * b, "R2 tap interval", n, 64 + 8 * b - 1);
        end

        // R5: load mid-run restarts from cleared counters
        do_load(5'd0);
        repeat (100) @(negedge clk_ref);
        do_load(5'd3);
        chk(!tap_pulse && !cmp_pulse, "R5 quiet in clear", int'({tap_pulse, cmp_pulse}), 0);
        wait_strobe(1'b1, 7000, n);
        chk(n == 720, "R5 reload latency", n, 720);

        // R6: selection changes without load are ignored
        do_load(5'd0);
        cfg_sel = 5'b11111;
        wait_strobe(1'b1, 7000, n);
        chk(n == 512, "R6 sel ignored first", n, 512);
        wait_strobe(1'b1, 7000, n);
        chk(n == 512, "R6 sel ignored interval", n, 512);

        // R7: pause of 13 sampled edges delays the first tap by 13
        do_load(5'd0);
        n = 0;
        forever begin
            @(negedge clk_ref);
            n++;
            if (tap_pulse || n >= 200) break;
            if (n == 20) run_en = 1'b0;
            if (n > 20 && n < 33) begin
                chk(!tap_pulse, "R7 quiet while halted", int'(tap_pulse), 0);
            end
            if (n == 33) run_en = 1'b1;
        end
        chk(n == 77, "R7 pause holds count", n, 77);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end
endmodule